// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block sets the strobe timing of programmed-I/O read and write cycles on an IDE channel that carries two drives. A small indexed register file holds one pair of timing registers per drive bank, a read-cycle register and a write-cycle register. It also holds a shared miscellaneous register and a read-only strap register. Software opens register access by writing a fixed key to the control index. It then selects a bank through the bank-index bit of the miscellaneous register and programs the timing registers of that bank.

When the host requests a cycle, the block latches the timing of the addressed drive and direction. It then runs three phases: address setup, active strobe and recovery. The read or write strobe is high only during the active phase. A single done pulse marks the last recovery clock. Drive 0 always uses bank A, drive 1 always uses bank B, and one setup time applies to both drives.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, access is locked, every register index reads 0x00, both strobes and `cyc_done` are low, `prefetch_en` is low, and all timing fields hold their minimum values (setup 1, active 1, recovery 2 clocks).
- R2: A write of 0xC0 to index 3 unlocks access, and a write of any other value to index 3 locks it again. Index 3 reads 0xC0 while unlocked and 0x00 while locked.
- R3: While access is locked, writes to indices 0, 1, 5 and 6 have no effect, and reads of every index other than 3 return 0x00.
- R4: Bit 0 of the miscellaneous register (index 6) selects the bank that writes and reads of index 0 (read timing) and index 1 (write timing) reach: 0 selects bank A and 1 selects bank B.
- R5: In a timing register, bits 7:4 hold the active strobe width minus 1 (1 to 16 clocks) and bits 3:0 hold the recovery time minus 2 (2 to 17 clocks).
- R6: Bits 5:4 of index 6 hold the address setup time minus 1 (1 to 4 clocks). This value applies to cycles of both drives.
- R7: A cycle for drive 0 takes its timing from bank A and a cycle for drive 1 from bank B. A read cycle uses the index 0 register and a write cycle uses the index 1 register.
- R8: An accepted cycle starts on the clock after the request and passes through setup, active, recovery and back to idle. `rd_strobe` is high only in the active phase of a read, `wr_strobe` only in the active phase of a write.
- R9: `cyc_done` is high for exactly the last recovery clock of each cycle. A request is accepted only while the block is idle, and a request raised during a cycle is ignored.
- R10: Bit 6 of index 6 drives `prefetch_en`, and bits 2:1 hold the ready-delay value minus 2. Index 6 keeps only bits 6, 5, 4, 2, 1 and 0 (mask 0x77), and the other bits read as zero.
- R11: Index 5 reads the `strap_clk25` input in bit 0 (1 means a 25 MHz bus, 0 means 33 MHz) with the other bits zero. Writes to index 5 have no effect.
- R12: The timing of a cycle is fixed when the cycle is accepted. A register write during a running cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| cyc_req | input | 1 | Host cycle request |
| cyc_drive | input | 1 | Drive addressed by the request |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| cyc_done | output | 1 | Pulse on the last recovery clock |
| prefetch_en | output | 1 | Read prefetch enable from the miscellaneous register |

## Verification
Two cases are hard to reach from the ports. The first is a request that arrives while a cycle is still running. The second is a register write that lands during a cycle and must not stretch or shorten the phases already latched. The bench raises a second request with a different drive and direction part way through a long cycle. It also rewrites the active timing register during a cycle. A behavioural model built on a queue of expected phases is compared with the strobes, `cyc_done` and the read data on every clock. The extreme settings (setup 4, active 16, recovery 17) and the relock path are driven as directed cases.

// File: rtl/pio_timer_pkg.sv
// Shared constants and types of the PIO cycle timer.
// Assumes an 8-bit indexed register file and two drive banks.
package pio_timer_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned NBANK   = 2;
    localparam int unsigned BANK_W  = $clog2(NBANK);
    localparam int unsigned ACT_W   = 4;
    localparam int unsigned REC_W   = 4;
    localparam int unsigned SET_W   = 2;
    localparam int unsigned ACT_LSB = 4;
    localparam int unsigned REC_LSB = 0;
    localparam int unsigned SET_LSB = 4;
    localparam int unsigned PF_BIT  = 6;
    localparam int unsigned BANK_LSB = 0;
    // longest phase is recovery: (2^REC_W - 1) + 2 clocks, counter holds len-1
    localparam int unsigned CNT_W   = $clog2((1 << REC_W) + 2);

    localparam logic [ADDR_W-1:0] IDX_RDTIM = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_WRTIM = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_CTL   = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_STRAP = 3'd5;
    localparam logic [ADDR_W-1:0] IDX_MISC  = 3'd6;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hC0;
    localparam logic [DATA_W-1:0] MISC_MASK  = 8'h77;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_t;

    typedef struct packed {
        logic [SET_W-1:0] setup;
        logic [ACT_W-1:0] act;
        logic [REC_W-1:0] rec;
    } cyc_timing_t;
endpackage

// File: rtl/pio_reg_file.sv
// Indexed configuration registers: unlock control, per-bank read and
// write timing, shared misc register, strap readback.
// Assumes writes take effect on the clock edge where cfg_we is high.
module pio_reg_file
    import pio_timer_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [DATA_W-1:0]               cfg_wdata,
    input  logic                            strap_clk25,
    output logic [DATA_W-1:0]               cfg_rdata,
    output logic                            unlocked,
    output logic [NBANK-1:0][DATA_W-1:0]    rd_tim,
    output logic [NBANK-1:0][DATA_W-1:0]    wr_tim,
    output logic [SET_W-1:0]                setup_f,
    output logic                            prefetch
);
    logic [DATA_W-1:0] misc_q;
    logic [BANK_W-1:0] bank_sel;
    logic              open_wr;

    assign bank_sel = misc_q[BANK_LSB +: BANK_W];
    assign open_wr  = cfg_we && unlocked;

    // Unlock latch: the key opens access, any other control value closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (cfg_we && cfg_addr == IDX_CTL)
            unlocked <= (cfg_wdata == UNLOCK_KEY);
    end

    // Misc register: keeps only the defined field bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            misc_q <= '0;
        else if (open_wr && cfg_addr == IDX_MISC)
            misc_q <= cfg_wdata & MISC_MASK;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DATA_W-1:0] rd_q;
        logic [DATA_W-1:0] wr_q;
        logic              hit;

        assign hit = open_wr && (bank_sel == BANK_W'(b));

        // Per-bank timing registers, written only when this bank is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
                wr_q <= '0;
            end else if (hit) begin
                if (cfg_addr == IDX_RDTIM) rd_q <= cfg_wdata;
                if (cfg_addr == IDX_WRTIM) wr_q <= cfg_wdata;
            end
        end

        assign rd_tim[b] = rd_q;
        assign wr_tim[b] = wr_q;
    end

    // Read mux: control always visible, everything else gated by the lock.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == IDX_CTL) begin
            cfg_rdata = unlocked ? UNLOCK_KEY : '0;
        end else if (unlocked) begin
            case (cfg_addr)
                IDX_RDTIM: cfg_rdata = rd_tim[bank_sel];
                IDX_WRTIM: cfg_rdata = wr_tim[bank_sel];
                IDX_STRAP: cfg_rdata = {{(DATA_W-1){1'b0}}, strap_clk25};
                IDX_MISC:  cfg_rdata = misc_q;
                default:   cfg_rdata = '0;
            endcase
        end
    end

    assign setup_f  = misc_q[SET_LSB +: SET_W];
    assign prefetch = misc_q[PF_BIT];
endmodule

// File: rtl/pio_timing_sel.sv
// Picks the timing fields for a requested cycle: bank by drive,
// register by direction, setup from the shared misc field.
// Purely combinational; the sequencer latches the result.
module pio_timing_sel
    import pio_timer_pkg::*;
(
    input  logic [NBANK-1:0][DATA_W-1:0] rd_tim,
    input  logic [NBANK-1:0][DATA_W-1:0] wr_tim,
    input  logic [SET_W-1:0]             setup_f,
    input  logic [BANK_W-1:0]            drive,
    input  logic                         write,
    output cyc_timing_t                  tim
);
    logic [DATA_W-1:0] sel;

    // Choose direction register of the addressed bank and split its nibbles.
    always_comb begin
        sel       = write ? wr_tim[drive] : rd_tim[drive];
        tim.setup = setup_f;
        tim.act   = sel[ACT_LSB +: ACT_W];
        tim.rec   = sel[REC_LSB +: REC_W];
    end
endmodule

// File: rtl/pio_phase_seq.sv
// Three-phase cycle sequencer: setup, active strobe, recovery.
// Accepts a request only when idle and latches the timing at acceptance.
// Each phase counter is loaded with phase length minus one.
module pio_phase_seq
    import pio_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        write,
    input  cyc_timing_t tim_in,
    output phase_t      phase,
    output logic        rd_strobe,
    output logic        wr_strobe,
    output logic        done
);
    cyc_timing_t      tim_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == '0);

    // Phase state and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tim_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    phase <= PH_SETUP;
                    cnt   <= CNT_W'(tim_in.setup);
                    tim_q <= tim_in;
                    wr_q  <= write;
                end
                PH_SETUP: if (last) begin
                    phase <= PH_ACTIVE;
                    cnt   <= CNT_W'(tim_q.act);
                end else cnt <= cnt - 1'b1;
                PH_ACTIVE: if (last) begin
                    phase <= PH_RECOV;
                    cnt   <= CNT_W'(tim_q.rec) + CNT_W'(1);
                end else cnt <= cnt - 1'b1;
                PH_RECOV: if (last) phase <= PH_IDLE;
                          else      cnt   <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Strobes decoded from the phase register, done on the final recovery clock.
    always_comb begin
        rd_strobe = (phase == PH_ACTIVE) && !wr_q;
        wr_strobe = (phase == PH_ACTIVE) && wr_q;
        done      = (phase == PH_RECOV) && last;
    end
endmodule

// File: rtl/pio_cycle_timer.sv
// Top of the PIO cycle timer: register file, timing selection and
// phase sequencer for a two-drive channel.
// Assumes the host holds cyc_drive/cyc_write valid with cyc_req.
module pio_cycle_timer
    import pio_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              strap_clk25,
    input  logic              cyc_req,
    input  logic              cyc_drive,
    input  logic              cyc_write,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              cyc_done,
    output logic              prefetch_en
);
    logic [NBANK-1:0][DATA_W-1:0] rd_tim;
    logic [NBANK-1:0][DATA_W-1:0] wr_tim;
    logic [SET_W-1:0]             setup_f;
    logic                         cfg_unlocked;
    cyc_timing_t                  req_tim;
    phase_t                       seq_phase;

    pio_reg_file u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .strap_clk25 (strap_clk25),
        .cfg_rdata   (cfg_rdata),
        .unlocked    (cfg_unlocked),
        .rd_tim      (rd_tim),
        .wr_tim      (wr_tim),
        .setup_f     (setup_f),
        .prefetch    (prefetch_en)
    );

    pio_timing_sel u_sel (
        .rd_tim  (rd_tim),
        .wr_tim  (wr_tim),
        .setup_f (setup_f),
        .drive   (BANK_W'(cyc_drive)),
        .write   (cyc_write),
        .tim     (req_tim)
    );

    pio_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cyc_req),
        .write     (cyc_write),
        .tim_in    (req_tim),
        .phase     (seq_phase),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .done      (cyc_done)
    );
endmodule

// File: rtl/pio_cycle_timer_chk.sv
// Property checker for the PIO cycle timer, attached by bind.
module pio_cycle_timer_chk
    import pio_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic              cyc_done,
    input logic              prefetch_en,
    input phase_t            phase,
    input logic              unlocked
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R8
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_strobe) || $rose(wr_strobe)) |-> $past(phase) == PH_SETUP);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done && phase == PH_IDLE);

    // R9
    done_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> !rd_strobe && !wr_strobe);

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == IDX_CTL && cfg_wdata == UNLOCK_KEY) |=> unlocked);

    // R3
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && cfg_addr != IDX_CTL) |-> cfg_rdata == '0);

    // R10
    prefetch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prefetch_en) |-> $past(cfg_we && unlocked && cfg_addr == IDX_MISC));
endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .cyc_done    (cyc_done),
    .prefetch_en (prefetch_en),
    .phase       (seq_phase),
    .unlocked    (cfg_unlocked)
);

// File: tb/pio_cycle_timer_test.sv
// Bench: behavioural phase-queue model compared every clock, plus
// directed phase-length measurements.
module pio_cycle_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = 3'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       strap_clk25 = 1'b0;
    logic       cyc_req = 1'b0;
    logic       cyc_drive = 1'b0;
    logic       cyc_write = 1'b0;
    logic       rd_strobe, wr_strobe, cyc_done, prefetch_en;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pio_cycle_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_clk25(strap_clk25),
        .cyc_req(cyc_req), .cyc_drive(cyc_drive), .cyc_write(cyc_write),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .cyc_done(cyc_done),
        .prefetch_en(prefetch_en)
    );

    // ---------------- reference model ----------------
    int  m_tim [2][2];   // [bank][0=read,1=write]
    int  m_misc;
    bit  m_unl;
    int  m_q[$];
    int  m_ph;           // 0 idle 1 setup 2 active 3 recovery
    bit  m_wr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin m_tim[b][0] = 0; m_tim[b][1] = 0; end
            m_misc = 0; m_unl = 0; m_q.delete(); m_ph = 0; m_wr = 0;
        end else begin
            if (m_q.size() > 0) m_ph = m_q.pop_front();
            else if (m_ph == 0 && cyc_req) begin
                int t, s, a, r;
                t = m_tim[cyc_drive][cyc_write];
                s = ((m_misc >> 4) & 3) + 1;
                a = ((t >> 4) & 15) + 1;
                r = (t & 15) + 2;
                for (int i = 0; i < s; i++) m_q.push_back(1);
                for (int i = 0; i < a; i++) m_q.push_back(2);
                for (int i = 0; i < r; i++) m_q.push_back(3);
                m_wr = cyc_write;
                m_ph = m_q.pop_front();
            end else m_ph = 0;
            if (cfg_we) begin
                if (cfg_addr == 3) m_unl = (cfg_wdata == 8'hC0);
                else if (m_unl) begin
                    if (cfg_addr == 0) m_tim[m_misc & 1][0] = cfg_wdata;
                    if (cfg_addr == 1) m_tim[m_misc & 1][1] = cfg_wdata;
                    if (cfg_addr == 6) m_misc = cfg_wdata & 8'h77;
                end
            end
        end
    end

    function automatic int exp_rdata(input int a);
        if (a == 3) return m_unl ? 8'hC0 : 0;
        if (!m_unl) return 0;
        case (a)
            0: return m_tim[m_misc & 1][0];
            1: return m_tim[m_misc & 1][1];
            5: return int'(strap_clk25);
            6: return m_misc;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            string rtag;
            int a;
            a = int'(cfg_addr);
            rtag = (a == 3) ? "R2" : (!m_unl) ? "R3" : (a == 5) ? "R11" :
                   (a == 6) ? "R10" : "R4";
            check(rtag, "cfg_rdata", int'(cfg_rdata), exp_rdata(a));
            check("R8", "rd_strobe", int'(rd_strobe), int'(m_ph == 2 && !m_wr));
            check("R8", "wr_strobe", int'(wr_strobe), int'(m_ph == 2 && m_wr));
            check("R9", "cyc_done", int'(cyc_done), int'(m_ph == 3 && m_q.size() == 0));
            check("R10", "prefetch_en", int'(prefetch_en), (m_misc >> 6) & 1);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input int exp);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1;
        check(req, "read", int'(cfg_rdata), exp);
    endtask

    // Run one cycle and measure its phases from the ports.
    task automatic run_cycle(input string req, input bit drv, input bit w,
                             input int es, input int ea, input int er);
        int s, a, r;
        bit saw_other;
        s = 0; a = 0; r = 0; saw_other = 0;
        @(negedge clk);
        cyc_req = 1'b1; cyc_drive = drv; cyc_write = w;
        @(negedge clk);
        cyc_req = 1'b0;
        while (!(rd_strobe || wr_strobe)) begin s++; @(negedge clk); end
        while (rd_strobe || wr_strobe) begin
            a++;
            if ((w && rd_strobe) || (!w && wr_strobe)) saw_other = 1;
            @(negedge clk);
        end
        forever begin r++; if (cyc_done) break; @(negedge clk); end
        check(req, "setup clocks", s, es);
        check(req, "active clocks", a, ea);
        check(req, "recovery clocks", r, er);
        check("R8", "strobe direction", int'(saw_other), 0);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rd_strobe", int'(rd_strobe), 0);
        check("R1", "cyc_done", int'(cyc_done), 0);
        check("R1", "prefetch_en", int'(prefetch_en), 0);
        check("R1", "rdata idx3", int'(cfg_rdata), 0);
        rst_n = 1'b1;
        rd("R1", 3, 0);
        run_cycle("R1", 0, 0, 1, 1, 2);

        // R3 locked writes ignored
        wr(0, 8'h5B); wr(6, 8'h30); wr(1, 8'hFF);
        rd("R3", 0, 0); rd("R3", 6, 0); rd("R3", 5, 0);
        run_cycle("R3", 0, 0, 1, 1, 2);
        run_cycle("R3", 0, 1, 1, 1, 2);

        // R2 unlock
        wr(3, 8'hC0);
        rd("R2", 3, 8'hC0);
        rd("R3", 0, 0);

        // program banks (R4)
        wr(6, 8'h20);
        wr(0, 8'h5B); wr(1, 8'h21);
        wr(6, 8'h21);
        wr(0, 8'h32); wr(1, 8'h10);
        rd("R4", 0, 8'h32); rd("R4", 1, 8'h10);
        wr(6, 8'h20);
        rd("R4", 0, 8'h5B); rd("R4", 1, 8'h21);

        // R5 R6 R7 timing selection
        run_cycle("R7", 0, 0, 3, 6, 13);
        run_cycle("R7", 0, 1, 3, 3, 3);
        run_cycle("R7", 1, 0, 3, 4, 4);
        run_cycle("R7", 1, 1, 3, 2, 2);
        wr(6, 8'h01);
        run_cycle("R6", 1, 1, 1, 2, 2);
        run_cycle("R6", 0, 0, 1, 6, 13);
        wr(6, 8'h30);
        wr(0, 8'hFF);
        run_cycle("R5", 0, 0, 4, 16, 17);
        wr(0, 8'h00);
        run_cycle("R5", 0, 0, 4, 1, 2);

        // R9 request during a busy cycle is ignored, R12 write mid-cycle
        wr(0, 8'hF8);
        @(negedge clk);
        cyc_req = 1'b1; cyc_drive = 1'b0; cyc_write = 1'b0;
        @(negedge clk);
        cyc_req = 1'b0;
        repeat (5) @(negedge clk);
        cyc_req = 1'b1; cyc_drive = 1'b1; cyc_write = 1'b1;
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h00;
        @(negedge clk);
        cyc_req = 1'b0; cfg_we = 1'b0;
        repeat (40) @(negedge clk);
        run_cycle("R12", 0, 0, 4, 1, 2);

        // back-to-back requests held high
        wr(6, 8'h00);
        @(negedge clk);
        cyc_req = 1'b1; cyc_drive = 1'b1; cyc_write = 1'b0;
        repeat (30) @(negedge clk);
        cyc_req = 1'b0;
        repeat (10) @(negedge clk);

        // R10 misc fields
        wr(6, 8'h46);
        check("R10", "prefetch_en", int'(prefetch_en), 1);
        rd("R10", 6, 8'h46);
        wr(6, 8'hFF);
        rd("R10", 6, 8'h77);
        wr(6, 8'h00);
        check("R10", "prefetch_en", int'(prefetch_en), 0);

        // R11 strap
        strap_clk25 = 1'b1;
        rd("R11", 5, 1);
        wr(5, 8'h00);
        rd("R11", 5, 1);
        strap_clk25 = 1'b0;
        rd("R11", 5, 0);

        // R2 relock and reopen
        wr(0, 8'h43);
        wr(3, 8'h00);
        rd("R2", 3, 0);
        rd("R3", 0, 0);
        wr(0, 8'h11);
        wr(3, 8'hC0);
        rd("R2", 0, 8'h43);
        run_cycle("R5", 0, 0, 1, 5, 5);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule